// File: doc/BRIEF.md
# Address-Muxed General-Purpose I/O Port

This block controls one 8-bit port of a microcontroller. Every pin can be a plain input, a plain output driven from a data register, or an output that carries one of the upper external address lines (bit 7 carries A23, bit 0 carries A16). The role of a pin depends on four things: the chip operating mode, an expansion-enable input, a per-pin address-enable register and a per-pin direction register.

Software reaches four registers through a small synchronous bus. The direction register is at index 0, the output data register at index 1, the read-only pin-state view at index 2, and the address-enable register at index 3. Reading index 1 returns a mix: the latched data bit for each output pin and the sampled pin level for each input pin. Pin levels pass through a two-flop synchroniser before they reach any read path. The block also takes a hardware-standby input, which clears the output data, and a software-standby input, which freezes every register.

Top module: `addr_mux_gpio_port`

## Requirements
- R1: After reset, the direction, data and address-enable registers all read 0x00, and every `pin_oe` bit is 0.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) to index 0 (direction), index 1 (data) or index 3 (address enable) loads `bus_wdata` into that register at the clock edge. Reads of index 0 and index 3 return the stored value.
- R3: A read of index 1 returns, for each bit, the data register bit when the direction bit is 1 and the synchronised pin level when the direction bit is 0.
- R4: A read of index 2 returns the pin levels sampled through two flops: a level applied before edge k is returned after edge k+1. A bus write to index 2 changes no register.
- R5: While `hw_standby` is 1, the data register is cleared to 0x00 at the clock edge, taking priority over a bus write. Direction and address enable keep their values.
- R6: While `sw_standby` is 1 and `hw_standby` is 0, bus writes are ignored and all registers keep their contents.
- R7: Each `pin_oe` bit equals its direction bit. A direction bit of 0 makes the pin an input.
- R8: When `mode_addr` is 1 or `exp_en` is 1, a pin whose address-enable bit is 1 drives `addr_hi` on `pin_out` at the same bit position (bit 7 = A23 … bit 0 = A16).
- R9: When `mode_addr` and `exp_en` are both 0, or when the pin's address-enable bit is 0, `pin_out` carries the data register bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby, clears output data |
| sw_standby | input | 1 | Software standby, freezes registers |
| mode_addr | input | 1 | 1 = address-capable operating mode, 0 = single-chip mode |
| exp_en | input | 1 | Expansion enable, used in single-chip mode |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| addr_hi | input | 8 | Address lines A23..A16 from the address generator |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
A register write is due one edge later: the bench drives it after a falling edge, lets one rising edge pass and checks at the next falling edge, where `pin_oe`, `pin_out` and reads of index 0, 1 or 3 already show it, because those outputs are combinational from the registers. Pin levels take two rising edges, so the bench changes `pin_in` after a falling edge and reads index 1 or 2 only two falling edges later. Mode, expansion and address-line changes are combinational, so the bench checks them a time step after driving them. Standby effects are checked one edge after the input is raised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1,
    REG_PINS = 2'd2,
    REG_AEN  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int CW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = raw_in;
    for (int k = 1; k < STAGES; k++) stage_d[k] = stage_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= stage_d[k];
    end
  end

  assign sync_out = stage_q[STAGES-1];

  // Settling counter for the latency check
  logic [CW-1:0] settle_q;
  logic [CW-1:0] settle_d;
  assign settle_d = (settle_q == CW'(STAGES)) ? settle_q : settle_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else        settle_q <= settle_d;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      // R4: two-edge pin latency
      a_r4_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q == CW'(STAGES)) |-> (sync_out == $past(raw_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_standby,
  input  logic             sw_standby,
  input  logic             wr_req,
  input  gpio_reg_e        wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] aen_q
);
  logic             wr_ok;
  logic             dir_en, data_en, aen_en;
  logic [WIDTH-1:0] dir_d, data_d, aen_d;

  assign wr_ok = wr_req && !sw_standby && !hw_standby;

  always_comb begin
    dir_en  = wr_ok && (wr_idx == REG_DIR);
    aen_en  = wr_ok && (wr_idx == REG_AEN);
    data_en = hw_standby || (wr_ok && (wr_idx == REG_DATA));
    dir_d   = wr_data;
    aen_d   = wr_data;
    data_d  = hw_standby ? '0 : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      aen_q  <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (data_en) data_q <= data_d;
      if (aen_en)  aen_q  <= aen_d;
    end
  end

  // R5: hardware standby clears data, keeps direction and enables
  a_r5_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hw_standby |=> (data_q == '0) && $stable(dir_q) && $stable(aen_q));
  // R6: software standby freezes all registers
  a_r6_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_standby && !hw_standby) |=> $stable(dir_q) && $stable(data_q) && $stable(aen_q));
  // R4: writes to the pin view change nothing
  a_r4_pins_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_idx == REG_PINS) |=> $stable(dir_q) && $stable(data_q) && $stable(aen_q));
  // R2: data write lands
  a_r2_data_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_idx == REG_DATA && !sw_standby && !hw_standby) |=> (data_q == $past(wr_data)));
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_mode,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] aen,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] addr_line,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] out
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic use_addr;
      assign use_addr = addr_mode && aen[i];
      assign oe[i]    = dir[i];
      assign out[i]   = use_addr ? addr_line[i] : data[i];
    end
  endgenerate

  // R9: without address mode the data register reaches the pins
  a_r9_gpio_out: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mode |-> (out == data));
  // R8: fully enabled address mode mirrors the address lines
  a_r8_addr_out: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mode && (&aen)) |-> (out == addr_line));
endmodule

// File: rtl/addr_mux_gpio_port.sv
module addr_mux_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_standby,
  input  logic             sw_standby,
  input  logic             mode_addr,
  input  logic             exp_en,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] addr_hi,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);
  logic [WIDTH-1:0] dir_q, data_q, aen_q, pin_sync;
  logic             addr_mode;
  gpio_reg_e        idx;

  assign idx       = gpio_reg_e'(bus_addr);
  assign addr_mode = mode_addr || exp_en;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .wr_req(bus_sel && bus_wr), .wr_idx(idx), .wr_data(bus_wdata),
    .dir_q(dir_q), .data_q(data_q), .aen_q(aen_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync)
  );

  gpio_port_pinmux #(.WIDTH(WIDTH)) u_mux (
    .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .dir(dir_q), .aen(aen_q),
    .data(data_q), .addr_line(addr_hi), .oe(pin_oe), .out(pin_out)
  );

  always_comb begin
    unique case (idx)
      REG_DIR:  bus_rdata = dir_q;
      REG_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
      REG_PINS: bus_rdata = pin_sync;
      REG_AEN:  bus_rdata = aen_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R7: an input pin is never driven
  a_r7_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && idx == REG_DIR && !sw_standby && !hw_standby) |=> (pin_oe == $past(bus_wdata)));
  // R3: output bits read back the latched data
  a_r3_read_out_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == REG_DATA) |-> ((bus_rdata & pin_oe) == (data_q & pin_oe)));
endmodule

// File: tb/addr_mux_gpio_port_bench.sv
module addr_mux_gpio_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_standby = 0, sw_standby = 0, mode_addr = 0, exp_en = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, addr_hi = 0, pin_in = 0;
  logic [W-1:0] bus_rdata, pin_oe, pin_out;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_mux_gpio_port u_addr_mux_gpio_port (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .mode_addr(mode_addr), .exp_en(exp_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .addr_hi(addr_hi), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic logic [W-1:0] exp_pin_out(logic m, logic e, logic [W-1:0] aen,
                                               logic [W-1:0] data, logic [W-1:0] a);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ((m || e) && aen[i]) ? a[i] : data[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_read(logic [W-1:0] dir, logic [W-1:0] data,
                                            logic [W-1:0] pins);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = dir[i] ? data[i] : pins[i];
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, sdir, sdata, saen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    rd(0, r); check("R1 dir", r, 8'h00);
    rd(3, r); check("R1 aen", r, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    pin_in = 8'h00; @(negedge clk); @(negedge clk);
    rd(1, r); check("R1 data", r, 8'h00);

    // R2 / R7
    wr(0, 8'hA5); rd(0, r); check("R2 dir", r, 8'hA5); check("R7 oe", pin_oe, 8'hA5);
    wr(3, 8'h3C); rd(3, r); check("R2 aen", r, 8'h3C);
    wr(1, 8'hFF); check("R9 out", pin_out, 8'hFF);

    // R4 latency and write ignored
    pin_in = 8'h5A;
    @(negedge clk); rd(2, r); check("R4 one edge", r, 8'h00);
    @(negedge clk); rd(2, r); check("R4 two edges", r, 8'h5A);
    wr(2, 8'h00);
    rd(0, r); check("R4 dir kept", r, 8'hA5);
    rd(1, r); check("R4 read", r, exp_read(8'hA5, 8'hFF, 8'h5A));
    rd(3, r); check("R4 aen kept", r, 8'h3C);

    // R8 boundary: A23 on bit 7, A16 on bit 0
    wr(3, 8'h81); mode_addr = 1; addr_hi = 8'h81; wr(1, 8'h00); #1;
    check("R8 edge bits", pin_out, 8'h81);
    mode_addr = 0; #1; check("R9 no addr mode", pin_out, 8'h00);
    exp_en = 1; #1; check("R8 exp", pin_out, 8'h81);
    exp_en = 0;

    // R6
    sw_standby = 1;
    wr(1, 8'h77); wr(0, 8'h11); wr(3, 8'h22);
    sw_standby = 0;
    rd(0, r); check("R6 dir", r, 8'hA5);
    rd(3, r); check("R6 aen", r, 8'h81);
    check("R6 data", pin_out, 8'h00);

    // R5
    wr(1, 8'hC3);
    @(negedge clk); hw_standby = 1; bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'hEE;
    @(negedge clk); hw_standby = 0; bus_sel = 0; bus_wr = 0;
    check("R5 data", pin_out, 8'h00);
    rd(0, r); check("R5 dir", r, 8'hA5);
    rd(3, r); check("R5 aen", r, 8'h81);

    // Random sweep over mode, expansion, enable and direction
    for (int n = 0; n < 300; n++) begin
      sdir = W'($urandom); sdata = W'($urandom); saen = W'($urandom);
      wr(0, sdir); wr(1, sdata); wr(3, saen);
      mode_addr = 1'($urandom); exp_en = 1'($urandom);
      addr_hi = W'($urandom); pin_in = W'($urandom);
      @(negedge clk); @(negedge clk);
      check("R7 rnd", pin_oe, sdir);
      check("R8 R9 rnd", pin_out, exp_pin_out(mode_addr, exp_en, saen, sdata, addr_hi));
      rd(1, r); check("R3 rnd", r, exp_read(sdir, sdata, pin_in));
      rd(2, r); check("R4 rnd", r, pin_in);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule